// File: doc/BRIEF.md
# Multi-Lane Word-Aligned Deserializer

This block gathers a serial bit stream on each of several lanes and hands the result to the core as parallel words of `WORD_W` bits. The slow word clock is not a separate clock here. It is modelled as a one-cycle marker, `word_clk_i`, sampled on the fast bit clock. The marker fixes where each word begins. Word boundaries are placed `ALIGN_OFS` bits after the marker, which absorbs a fixed skew between the received word clock and the data. With the default offset of 2, the bit sampled in the marker cycle and the bit after it are the last two bits of the word already in flight. The third bit becomes the most significant bit of the next word.

All lanes share one phase tracker. Every lane therefore captures in the same fast cycle, and the words are packed side by side into one wide bus, with lane 0 in the lowest slice. A valid strobe marks each complete word. The strobe stays low until the first marker has been seen and a full word of bits has been gathered after it. When markers go missing, the tracker keeps the word rhythm on its own. When a marker arrives off schedule, the tracker realigns to it and drops the cut-short word.

Top module: `lane_deser`

## Requirements
- R1: Each lane word holds the last `WORD_W` bits sampled up to and including its boundary. The earliest of these bits lands in the word's most significant bit and the latest in bit 0.
- R2: If `word_clk_i` is high in cycle t, the first bit of the next word is the bit sampled in cycle t+`ALIGN_OFS`. With `ALIGN_OFS`=2, the bits sampled in cycles t and t+1 complete the previous word.
- R3: A word whose last bit is sampled in cycle c appears on `par_o` after the clock edge that ends cycle c. `valid_o` is high for exactly that one cycle and is low in every other cycle.
- R4: Lane k (counting from 0) occupies `par_o[k*WORD_W+WORD_W-1 : k*WORD_W]`. For `WORD_W`=8, lane 1 counted from one sits in bits 7..0, and lane 18 sits in bits 143..136.
- R5: All lanes update their slices of `par_o` in the same fast-clock cycle.
- R6: While `rst_ni` is low, `par_o` is all zeros and `valid_o` is low.
- R7: `valid_o` stays low until a first `word_clk_i` marker has been seen. A word boundary is flagged valid only if at least `WORD_W` bits have been sampled since the latest alignment, counting the bit of the marker cycle.
- R8: Once aligned, boundaries repeat every `WORD_W` cycles even when expected markers are absent. A marker that arrives exactly `WORD_W` cycles after the previous phase origin keeps the alignment unchanged.
- R9: A marker that arrives off schedule, or that is the first since reset, restarts the phase and the bit count. The word boundary that follows it is not flagged valid.
- R10: Between word boundaries, `par_o` holds its value.
- R11: `ALIGN_OFS` can be set anywhere from 0 to `WORD_W-1`, and `WORD_W` anywhere from 4 to 10. R2 holds for every such setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock; one serial bit per lane per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_clk_i | input | 1 | Word clock phase marker, one fast cycle wide |
| ser_i | input | NUM_LANES | Serial input bit of each lane |
| par_o | output | NUM_LANES*WORD_W | Packed parallel words, lane 0 in the lowest slice |
| valid_o | output | 1 | One-cycle strobe for a complete, aligned word |

## Verification
The bench builds three instances side by side:
- 18 lanes, 8-bit words, offset 2. This is the default, and it exercises the full packed width with the two-bit skew rule.
- 3 lanes, 4-bit words, offset 1. Here the boundary falls in the marker cycle itself, so a realigning marker and a capture coincide.
- 2 lanes, 10-bit words, offset 0. Here the boundary sits just before the marker.

Together these reach both width limits and three distinct offsets. Each instance runs the same sequence:
1. A silent lead-in with no markers.
2. Regular markers.
3. A run of skipped markers.
4. One early marker.
5. A random mix of skipped and stray markers.

// File: rtl/lane_deser_pkg.sv
package lane_deser_pkg;

  // Phase slot (0 = marker cycle) in which the last bit of a word is sampled
  function automatic int unsigned last_phase(int unsigned word_w, int unsigned ofs);
    return (ofs + word_w - 1) % word_w;
  endfunction

endpackage

// File: rtl/lane_deser_phase.sv
module lane_deser_phase
  import lane_deser_pkg::*;
#(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned ALIGN_OFS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic word_clk_i,
  output logic cap_o,
  output logic valid_o
);

  localparam int unsigned CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] LAST_SLOT = CW'(WORD_W - 1);
  localparam logic [CW-1:0] CAP_SLOT  = CW'(last_phase(WORD_W, ALIGN_OFS));
  localparam logic [CW-1:0] FULL      = CW'(WORD_W);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic [CW-1:0] ph_q, ph_d;
  logic [CW-1:0] fill_q, fill_d;
  logic          seen_q, seen_d;
  logic          valid_q, valid_d;
  logic          on_slot, resync;

  always_comb begin
    on_slot = (ph_q == LAST_SLOT);
    resync  = word_clk_i && (!seen_q || !on_slot);
    if (word_clk_i || on_slot) ph_d = '0;
    else                       ph_d = ph_q + ONE;
    if (resync)              fill_d = ONE;
    else if (fill_q == FULL) fill_d = FULL;
    else                     fill_d = fill_q + ONE;
    seen_d  = seen_q | word_clk_i;
    cap_o   = seen_d && (ph_d == CAP_SLOT);
    valid_d = cap_o && (fill_d == FULL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      fill_q  <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      fill_q  <= fill_d;
      seen_q  <= seen_d;
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R3
  AST_ALIGN_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_clk_i |=> (ph_q == '0)); // R2
  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q <= LAST_SLOT); // R8
  AST_FLYWHEEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && on_slot && !word_clk_i) |=> (ph_q == '0)); // R8
  AST_NO_VALID_UNALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> seen_q); // R7
  AST_RESYNC_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_clk_i && seen_q && !on_slot) |=> !valid_o); // R9

endmodule

// File: rtl/lane_deser_lane.sv
module lane_deser_lane #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_i,
  input  logic              cap_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      word_q <= '0;
    end else begin
      sh_q <= {sh_q[WORD_W-3:0], ser_i};
      if (cap_i) word_q <= {sh_q, ser_i};
    end
  end

  assign word_o = word_q;

  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(word_q)); // R10
  AST_LAST_BIT_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (word_q[0] == $past(ser_i))); // R1

endmodule

// File: rtl/lane_deser.sv
module lane_deser #(
  parameter int unsigned NUM_LANES = 18,
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned ALIGN_OFS = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          word_clk_i,
  input  logic [NUM_LANES-1:0]          ser_i,
  output logic [NUM_LANES*WORD_W-1:0]   par_o,
  output logic                          valid_o
);

  logic cap;

  lane_deser_phase #(
    .WORD_W   (WORD_W),
    .ALIGN_OFS(ALIGN_OFS)
  ) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_clk_i(word_clk_i),
    .cap_o     (cap),
    .valid_o   (valid_o)
  );

  // one shared capture strobe keeps every lane on the same word
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    lane_deser_lane #(
      .WORD_W(WORD_W)
    ) u_lane (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ser_i (ser_i[k]),
      .cap_i (cap),
      .word_o(par_o[k*WORD_W +: WORD_W])
    );
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> (!valid_o && par_o == '0)); // R6

endmodule

// File: tb/lane_deser_env.sv
module lane_deser_env #(
  parameter int unsigned LANES = 4,
  parameter int unsigned J     = 8,
  parameter int unsigned OFS   = 2
) (
  input  logic clk,
  output logic done
);

  logic               rst_n;
  logic               wclk;
  logic [LANES-1:0]   ser;
  logic [LANES*J-1:0] par;
  logic               valid;

  integer n_chk;
  integer n_fail;

  lane_deser #(
    .NUM_LANES(LANES),
    .WORD_W   (J),
    .ALIGN_OFS(OFS)
  ) u_lane_deser (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .word_clk_i(wclk),
    .ser_i     (ser),
    .par_o     (par),
    .valid_o   (valid)
  );

  // behavioural reference
  logic [LANES-1:0]   hist[$];
  logic [LANES*J-1:0] exp_par;
  logic               exp_valid;
  int                 m_k;
  bit                 m_seen;
  int                 m_fill;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      exp_par   = '0;
      exp_valid = 1'b0;
      m_k       = 0;
      m_seen    = 1'b0;
      m_fill    = 0;
    end else begin
      bit resync;
      bit boundary;
      hist.push_back(ser);
      if (hist.size() > J) void'(hist.pop_front());
      resync = 1'b0;
      if (wclk) begin
        resync = !m_seen || (((m_k + 1) % J) != 0);
        m_k    = 0;
        m_seen = 1'b1;
      end else begin
        m_k = m_k + 1;
      end
      if (resync) m_fill = 1;
      else if (m_fill < J) m_fill = m_fill + 1;
      boundary  = m_seen && ((m_k % J) == ((OFS + J - 1) % J));
      exp_valid = boundary && (m_fill >= J);
      if (boundary) begin
        for (int l = 0; l < LANES; l++) begin
          for (int i = 0; i < J; i++) begin
            int idx;
            idx = int'(hist.size()) - int'(J) + i;
            exp_par[l*J + (J - 1 - i)] = (idx >= 0) ? hist[idx][l] : 1'b0;
          end
        end
      end
    end
  end

  task automatic check_now();
    n_chk = n_chk + 1;
    if (valid !== exp_valid) begin
      n_fail = n_fail + 1;
      $display("FAIL R3 R6 R7 R8 R9 valid_o J=%0d OFS=%0d t=%0t actual %b expected %b",
               J, OFS, $time, valid, exp_valid);
    end
    n_chk = n_chk + 1;
    if (par !== exp_par) begin
      n_fail = n_fail + 1;
      $display("FAIL R1 R2 R4 R5 R10 R11 par_o J=%0d OFS=%0d t=%0t actual %h expected %h",
               J, OFS, $time, par, exp_par);
    end
  endtask

  int k;

  task automatic step(bit pulse);
    @(negedge clk);
    check_now();
    ser  = LANES'($urandom);
    wclk = pulse;
    if (pulse) k = 1;
    else       k = k + 1;
  endtask

  initial begin
    n_chk  = 0;
    n_fail = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    wclk   = 1'b0;
    ser    = '0;
    k      = 0;
    // R6: reset state
    for (int i = 0; i < 3; i++) step(1'b0);
    rst_n = 1'b1;
    // R7: no marker yet
    for (int i = 0; i < 13; i++) step(1'b0);
    // regular markers
    k = 0;
    for (int i = 0; i < 12 * int'(J); i++) step((k % J) == 0);
    // R8: markers missing, rhythm kept
    for (int i = 0; i < 4 * int'(J); i++) step(1'b0);
    for (int i = 0; i < 3 * int'(J); i++) step((k % J) == 0);
    // R9: early marker
    while ((k % J) != (J / 2)) step((k % J) == 0);
    step(1'b1);
    for (int i = 0; i < 5 * int'(J); i++) step((k % J) == 0);
    // mixed skips and stray markers
    for (int i = 0; i < 200; i++) begin
      bit p;
      p = (((k % J) == 0) && (($urandom % 6) != 0)) || (($urandom % 37) == 0);
      step(p);
    end
    for (int i = 0; i < 2 * int'(J); i++) step((k % J) == 0);
    done = 1'b1;
  end

endmodule

// File: tb/lane_deser_bench.sv
module lane_deser_bench;

  logic clk;
  logic d0, d1, d2;
  bit   timeout;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  lane_deser_env #(.LANES(18), .J(8),  .OFS(2)) u_env0 (.clk(clk), .done(d0));
  lane_deser_env #(.LANES(3),  .J(4),  .OFS(1)) u_env1 (.clk(clk), .done(d1));
  lane_deser_env #(.LANES(2),  .J(10), .OFS(0)) u_env2 (.clk(clk), .done(d2));

  initial begin
    integer runs;
    integer fails;
    timeout = 1'b0;
    fork
      begin
        wait (d0 && d1 && d2);
      end
      begin
        repeat (20000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    @(negedge clk);
    runs  = u_env0.n_chk + u_env1.n_chk + u_env2.n_chk;
    fails = u_env0.n_fail + u_env1.n_fail + u_env2.n_fail;
    if (timeout && !(d0 && d1 && d2)) begin
      runs  = runs + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run did not complete, actual done=%b%b%b expected 111", d0, d1, d2);
    end
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

endmodule